// File: doc/BRIEF.md
# LED Dot-Matrix Column Scanner

This block drives a 5-column by 7-row LED dot-matrix display. Rows and columns are multiplexed, so only 12 drive lines are needed. One column sinks current at a time: it is driven low, and the other four are held high so that they have no ground path. While a column is selected, the 7 row lines carry that column's slice of the current character, active high. A divided system clock sets how long each column stays lit. The column ring moves from C1 to C5 and then wraps. With a long enough dwell, the eye sees a still glyph.

A push key steps through the stored characters: the digits 0 to 9, then the letter 'A'. The key input is synchronised and edge-detected, so each press moves the character index by exactly one step, however long the key is held. A mode switch sets the direction of that step. The column lines and the row lines are loaded by the same register stage on the same clock edge. A column is therefore never shown with another column's row data.

Top module: `dm_matrix_scanner`

## Requirements
- R1: While reset is asserted, and after it until the first scan tick, `col_n_o` is 5'b11111 and `row_o` is 0. The character index restarts at 0 (digit '0').
- R2: At most one column line is low at any time. `col_n_o[k]` drives column C(k+1). After reset, the first active column is C1 (5'b11110). Each later step moves the single low bit from C(k) to C(k+1), and from C5 back to C1.
- R3: Once scanning has started, every column stays selected for exactly `DIV_MAX` clock cycles.
- R4: A rising edge on `key_i` changes the character index by exactly one step, whatever the hold time. With no key edge, the index never changes.
- R5: With `mode_i` low, a press increments the index, and the step from 10 ('A') wraps to 0. With `mode_i` high, a press decrements it, and the step from 0 wraps to 10. The index order is digits 0 to 9 at indices 0 to 9, then 'A' at index 10.
- R6: `row_o[j]` drives row R(j+1). Whenever a new column is selected, `row_o` carries the font slice of the current character for that column, taken on the same edge. Neither bus changes between scan ticks.
- R7: The font slices for columns C1 to C5 are given below in hex, with bit 0 = R1. Only the letter 'A' has required slices: its C1 slice lights R2 to R7, and its C2 slice lights only R1 and R5. The digit slices are chosen for this block.

| Char | C1 | C2 | C3 | C4 | C5 |
|------|----|----|----|----|----|
| 0 | 3E | 51 | 49 | 45 | 3E |
| 1 | 00 | 42 | 7F | 40 | 00 |
| 2 | 42 | 61 | 51 | 49 | 46 |
| 3 | 21 | 41 | 45 | 4B | 31 |
| 4 | 18 | 14 | 12 | 7F | 10 |
| 5 | 27 | 45 | 45 | 45 | 39 |
| 6 | 3C | 4A | 49 | 49 | 30 |
| 7 | 01 | 71 | 09 | 05 | 03 |
| 8 | 36 | 49 | 49 | 49 | 36 |
| 9 | 06 | 49 | 49 | 29 | 1E |
| A | 7E | 11 | 11 | 11 | 7E |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_i | input | 1 | Push key that steps the character (asynchronous) |
| mode_i | input | 1 | Step direction: 0 = up, 1 = down (asynchronous) |
| col_n_o | output | 5 | Column selects, active low, bit k = C(k+1) |
| row_o | output | 7 | Row data, active high, bit j = R(j+1) |

## Verification
The bench starts with directed stepping. It walks up through every glyph to 'A', then over the upper wrap. It then steps down across the 0 boundary, which tells the two wrap directions apart. Seeded random presses follow, each with a random direction and a random hold time. These check that a long hold still gives a single step, and that direction changes between presses are honoured. Throughout the run, every column change is checked against the ring order, against the exact dwell and against the expected glyph slice. A reset in the middle of the run shows that the block returns to all columns off and the digit '0'.

// File: rtl/dm_pkg.sv
package dm_pkg;

    localparam int GLYPH_COLS = 5;
    localparam int GLYPH_ROWS = 7;
    localparam int NUM_GLYPHS = 11;
    localparam int CH_W       = $clog2(NUM_GLYPHS);
    localparam int COL_W      = $clog2(GLYPH_COLS);

    typedef logic [CH_W-1:0]       glyph_idx_t;
    typedef logic [COL_W-1:0]      col_idx_t;
    typedef logic [GLYPH_ROWS-1:0] slice_t;
    typedef logic [GLYPH_COLS-1:0] col_bus_t;

    // Registered state of the scan output stage
    typedef struct packed {
        col_idx_t idx;
        col_bus_t col_n;
        slice_t   row;
    } scan_state_t;

    // Glyph bitmaps, packed with column C5 in the top slot and C1 at the bottom
    function automatic slice_t glyph_slice(input glyph_idx_t ch, input col_idx_t col);
        logic [GLYPH_COLS*GLYPH_ROWS-1:0] g;
        case (ch)
            4'd0:    g = {7'h3E, 7'h45, 7'h49, 7'h51, 7'h3E};
            4'd1:    g = {7'h00, 7'h40, 7'h7F, 7'h42, 7'h00};
            4'd2:    g = {7'h46, 7'h49, 7'h51, 7'h61, 7'h42};
            4'd3:    g = {7'h31, 7'h4B, 7'h45, 7'h41, 7'h21};
            4'd4:    g = {7'h10, 7'h7F, 7'h12, 7'h14, 7'h18};
            4'd5:    g = {7'h39, 7'h45, 7'h45, 7'h45, 7'h27};
            4'd6:    g = {7'h30, 7'h49, 7'h49, 7'h4A, 7'h3C};
            4'd7:    g = {7'h03, 7'h05, 7'h09, 7'h71, 7'h01};
            4'd8:    g = {7'h36, 7'h49, 7'h49, 7'h49, 7'h36};
            4'd9:    g = {7'h1E, 7'h29, 7'h49, 7'h49, 7'h06};
            4'd10:   g = {7'h7E, 7'h11, 7'h11, 7'h11, 7'h7E};
            default: g = '0;
        endcase
        if (int'(col) < GLYPH_COLS) begin
            return g[int'(col)*GLYPH_ROWS +: GLYPH_ROWS];
        end
        return '0;
    endfunction

endpackage

// File: rtl/dm_scan_timer.sv
module dm_scan_timer #(
    parameter int DIV_MAX = 50000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int CW = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_MAX - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == LAST);
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assert_div_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);
    assert_div_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (cnt_q == '0) && !tick_o);
endmodule

// File: rtl/dm_key_edge.sv
module dm_key_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic key_i,
    input  logic mode_i,
    output logic press_o,
    output logic down_o
);
    typedef struct packed {
        logic [SYNC_STAGES:0]   key_sh;
        logic [SYNC_STAGES-1:0] mode_sh;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.key_sh  = {s_q.key_sh[SYNC_STAGES-1:0], key_i};
        s_d.mode_sh = {s_q.mode_sh[SYNC_STAGES-2:0], mode_i};
        press_o     = s_q.key_sh[SYNC_STAGES-1] & ~s_q.key_sh[SYNC_STAGES];
        down_o      = s_q.mode_sh[SYNC_STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        press_o |=> !press_o);
endmodule

// File: rtl/dm_char_counter.sv
module dm_char_counter
    import dm_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       press_i,
    input  logic       down_i,
    output glyph_idx_t ch_o
);
    localparam glyph_idx_t LAST = glyph_idx_t'(NUM_GLYPHS - 1);

    glyph_idx_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (press_i) begin
            if (down_i) ch_d = (ch_q == '0)   ? LAST : ch_q - 1'b1;
            else        ch_d = (ch_q == LAST) ? '0   : ch_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ch_q <= '0;
        else         ch_q <= ch_d;
    end

    assign ch_o = ch_q;

    assert_step_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (press_i && !down_i) |=>
            ch_q == (($past(ch_q) == LAST) ? glyph_idx_t'(0) : glyph_idx_t'($past(ch_q) + 1'b1)));
    assert_step_down_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (press_i && down_i) |=>
            ch_q == (($past(ch_q) == '0) ? LAST : glyph_idx_t'($past(ch_q) - 1'b1)));
    assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !press_i |=> $stable(ch_q));
    assert_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ch_q <= LAST);
endmodule

// File: rtl/dm_font_rom.sv
module dm_font_rom
    import dm_pkg::*;
(
    input  glyph_idx_t ch_i,
    input  col_idx_t   col_i,
    output slice_t     slice_o
);
    always_comb slice_o = glyph_slice(ch_i, col_i);
endmodule

// File: rtl/dm_matrix_scanner.sv
module dm_matrix_scanner
    import dm_pkg::*;
#(
    parameter int DIV_MAX     = 50000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       key_i,
    input  logic       mode_i,
    output logic [4:0] col_n_o,
    output logic [6:0] row_o
);
    localparam col_idx_t LAST_COL = col_idx_t'(GLYPH_COLS - 1);

    logic       tick, press, down;
    glyph_idx_t ch;
    slice_t     slice;
    scan_state_t st_d, st_q;

    dm_scan_timer #(.DIV_MAX(DIV_MAX)) u_timer (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

    dm_key_edge #(.SYNC_STAGES(SYNC_STAGES)) u_key (
        .clk_i(clk_i), .rst_ni(rst_ni), .key_i(key_i), .mode_i(mode_i),
        .press_o(press), .down_o(down));

    dm_char_counter u_chars (
        .clk_i(clk_i), .rst_ni(rst_ni), .press_i(press), .down_i(down), .ch_o(ch));

    dm_font_rom u_font (
        .ch_i(ch), .col_i(st_q.idx), .slice_o(slice));

    // Columns and rows are loaded together so they can never disagree
    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.col_n = ~(col_bus_t'(1) << st_q.idx);
            st_d.row   = slice;
            st_d.idx   = (st_q.idx == LAST_COL) ? '0 : st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.idx   <= '0;
            st_q.col_n <= '1;
            st_q.row   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_n_o = st_q.col_n;
    assign row_o   = st_q.row;

    function automatic col_bus_t ring_next(input col_bus_t c);
        return (c == '1) ? col_bus_t'(5'b11110) : {c[GLYPH_COLS-2:0], c[GLYPH_COLS-1]};
    endfunction

    assert_one_col_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~st_q.col_n));
    assert_ring_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick |=> st_q.col_n == ring_next($past(st_q.col_n)));
    assert_dark_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.col_n == '1) |-> (st_q.row == '0));
    assert_hold_between_ticks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick |=> $stable(st_q.col_n) && $stable(st_q.row));
endmodule

// File: tb/dm_matrix_scanner_test.sv
`timescale 1ns/1ps
module dm_matrix_scanner_test;
    localparam int DIV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key = 1'b0;
    logic mode = 1'b0;
    logic [4:0] col_n;
    logic [6:0] row;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int evt_cnt = 0;
    int last_cyc = 0;
    int exp_ch = 0;
    bit have_prev = 1'b0;
    bit row_en = 1'b0;
    logic [4:0] prev_col = 5'h1F;
    string tag = "R6";

    always #2.5 clk = ~clk;

    dm_matrix_scanner #(.DIV_MAX(DIV)) uut (
        .clk_i(clk), .rst_ni(rst_n), .key_i(key), .mode_i(mode),
        .col_n_o(col_n), .row_o(row));

    // Expected font, C1 slice first
    function automatic logic [6:0] font(input int ch, input int c);
        logic [39:0] g;
        case (ch)
            0:  g = {8'h3E, 8'h51, 8'h49, 8'h45, 8'h3E};
            1:  g = {8'h00, 8'h42, 8'h7F, 8'h40, 8'h00};
            2:  g = {8'h42, 8'h61, 8'h51, 8'h49, 8'h46};
            3:  g = {8'h21, 8'h41, 8'h45, 8'h4B, 8'h31};
            4:  g = {8'h18, 8'h14, 8'h12, 8'h7F, 8'h10};
            5:  g = {8'h27, 8'h45, 8'h45, 8'h45, 8'h39};
            6:  g = {8'h3C, 8'h4A, 8'h49, 8'h49, 8'h30};
            7:  g = {8'h01, 8'h71, 8'h09, 8'h05, 8'h03};
            8:  g = {8'h36, 8'h49, 8'h49, 8'h49, 8'h36};
            9:  g = {8'h06, 8'h49, 8'h49, 8'h29, 8'h1E};
            default: g = {8'h7E, 8'h11, 8'h11, 8'h11, 8'h7E};
        endcase
        return g[(4-c)*8 +: 7];
    endfunction

    task automatic chk(input string t, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", t, act, exp, cyc);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Column-change monitor: R2 ring order, R3 dwell, R6/R7 row content
    always @(negedge clk) begin
        logic [4:0] exp_col;
        int k;
        cyc++;
        if (!rst_n) begin
            prev_col  = 5'h1F;
            have_prev = 1'b0;
        end else if (col_n !== prev_col) begin
            exp_col = (prev_col == 5'h1F) ? 5'h1E : {prev_col[3:0], prev_col[4]};
            chk("R2 column ring", col_n === exp_col, int'(col_n), int'(exp_col));
            if (have_prev)
                chk("R3 dwell", (cyc - last_cyc) == DIV, cyc - last_cyc, DIV);
            k = 0;
            for (int i = 0; i < 5; i++) if (!exp_col[i]) k = i;
            if (row_en)
                chk({tag, " rows"}, row === font(exp_ch, k), int'(row), int'(font(exp_ch, k)));
            have_prev = 1'b1;
            last_cyc  = cyc;
            prev_col  = col_n;
            evt_cnt++;
        end
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
        end
    end

    task automatic wait_cols(input int n);
        int target;
        target = evt_cnt + n;
        while (evt_cnt < target) @(negedge clk);
    endtask

    task automatic press(input bit down, input int hold, input string t);
        row_en = 1'b0;
        mode = down;
        repeat (4) @(negedge clk);
        key = 1'b1;
        repeat (hold) @(negedge clk);
        key = 1'b0;
        repeat (4) @(negedge clk);
        exp_ch = down ? ((exp_ch == 0) ? 10 : exp_ch - 1) : ((exp_ch == 10) ? 0 : exp_ch + 1);
        repeat (2 * DIV + 2) @(negedge clk);
        tag = t;
        row_en = 1'b1;
        wait_cols(5);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 reset cols", col_n === 5'h1F, int'(col_n), 32'h1F);
        chk("R1 reset rows", row === 7'h00, int'(row), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle cols before first tick", col_n === 5'h1F, int'(col_n), 32'h1F);
        chk("R1 idle rows before first tick", row === 7'h00, int'(row), 0);
        tag = "R1 start glyph";
        row_en = 1'b1;
        wait_cols(10);

        // R4/R5/R7: walk up through every glyph to 'A'
        for (int i = 0; i < 10; i++) press(1'b0, 2, "R7 glyph");
        chk("R7 at letter A", exp_ch == 10, exp_ch, 10);
        press(1'b0, 3, "R5 up wrap");
        press(1'b1, 3, "R5 down wrap");
        press(1'b1, 2, "R5 down");
        press(1'b0, 60, "R4 long hold");

        // Random presses with random direction and hold
        for (int i = 0; i < 30; i++)
            press(1'(($urandom() % 3) == 0), 1 + int'($urandom() % 40), "R4 random");

        // R4: no key activity, no change over many frames
        tag = "R4 idle";
        wait_cols(25);

        // R1: reset in the middle of a frame
        @(negedge clk);
        rst_n = 1'b0;
        row_en = 1'b0;
        @(negedge clk);
        chk("R1 mid reset cols", col_n === 5'h1F, int'(col_n), 32'h1F);
        chk("R1 mid reset rows", row === 7'h00, int'(row), 0);
        exp_ch = 0;
        rst_n = 1'b1;
        tag = "R1 glyph after reset";
        row_en = 1'b1;
        wait_cols(10);
        report();
    end
endmodule